// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Controller

This block arbitrates the eight interrupt sources of a small 8-bit microcontroller core and tells the core where to jump. Four sources are active-low external pins, two are timer overflow flags, one is the OR of a serial receive flag and a serial transmit flag, and one is the OR of a third timer's overflow flag and its capture flag. The block keeps all request flags itself. It captures the external pins in either level or falling-edge mode and takes the set pulses of the timers and the serial unit. Software can write every flag, and hardware clears the flags that need clearing when a vector is taken.

At each instruction boundary strobe the block chooses the best eligible request. A request is eligible when it is pending, its own enable is set, the global enable is set, and its two-bit priority level is strictly above the highest level in service. A higher level wins. Within a level the lower source index wins. The chosen vector address is presented and held until the core acknowledges it. On the acknowledge the block marks the level as in service. A return pulse from the core removes the highest in-service level, which allows nesting across four levels.

Top module: `ivc_top`

## Requirements
- R1: A source can produce a vector only when its enable bit (register 0, bit = source index) and the global enable (register 1, bit 0) are both set.
- R2: A source's level is {bit i of register 2, bit i of register 3}, giving 0 to 3. Among eligible requests the highest level is chosen.
- R3: Among eligible requests of equal level, the lowest source index is chosen. The indices are: ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5, ext2=6, ext3=7.
- R4: On the clock edge where the instruction boundary strobe is sampled with a request eligible and no vector held, vec_valid rises. vec_addr is 0x03 + 8×index. Both hold unchanged until vec_ack is sampled, and vec_valid falls on that edge.
- R5: An acknowledge marks the vector's level as in service. Only a request with a level strictly above the highest in-service level is eligible. An irq_ret pulse removes the highest in-service level.
- R6: The external inputs are active low. Register 4 bit j selects the mode of external input j: 1 is falling edge, which sets the flag, and 0 is level, where the flag follows the pin.
- R7: On acknowledge, an edge-mode external flag and the timer0 and timer1 flags are cleared. A level-mode external flag keeps requesting while its pin stays low.
- R8: The serial request is rx|tx and the timer2 request is overflow|capture. None of these flags is cleared on acknowledge.
- R9: A software write replaces the flags. Register 5 holds [3:0] ext0..ext3 and [5:4] timer0/timer1. Register 6 holds [0] rx, [1] tx, [2] timer2 overflow and [3] timer2 capture. A flag written to 1 requests service, and a flag written to 0 withdraws it.
- R10: After reset every register is zero and no vector is presented.
- R11: A one-cycle set pulse on a timer, serial or timer2 flag input sets the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_bnd | input | 1 | Instruction boundary strobe; arbitration sample point |
| vec_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| ext_n | input | 4 | Active-low external request pins ext0..ext3 |
| tmr_ovf | input | 2 | Set pulses for timer0 / timer1 flags |
| ser_rx | input | 1 | Set pulse, serial receive flag |
| ser_tx | input | 1 | Set pulse, serial transmit flag |
| t2_ovf | input | 1 | Set pulse, timer2 overflow flag |
| t2_ext | input | 1 | Set pulse, timer2 capture flag |
| vec_valid | output | 1 | A vector is presented |
| vec_addr | output | 8 | Presented vector address |

## Verification
The assertions check on every cycle that a presented vector stays stable until acknowledged, that it drops on the acknowledge, that no vector appears without a strobe while global enable is set, that a new vector always lies above the in-service level it nests into, and that acknowledge and return update the in-service set. Which source wins under a given mix of enables and levels can only be shown by the bench scenarios. The same holds for which flags survive an acknowledge, how edge and level pins differ, and whether software writes raise or cancel requests. The bench follows each of these through the vector address and through repeated strobes.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  parameter int unsigned NSRC   = 8;
  parameter int unsigned PRIO_W = 2;
  parameter int unsigned NLVL   = 1 << PRIO_W;
  parameter int unsigned IDX_W  = $clog2(NSRC);
  parameter int unsigned NEXT   = 4;
  parameter int unsigned ADDR_W = 3;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned VEC_W  = 8;
  parameter int unsigned FLG_W  = 6;

  // Vector = base + stride * index
  parameter logic [2:0] VEC_LOW = 3'b011;

  typedef enum logic [ADDR_W-1:0] {
    RA_EN   = 3'd0,
    RA_GEN  = 3'd1,
    RA_PHI  = 3'd2,
    RA_PLO  = 3'd3,
    RA_TYPE = 3'd4,
    RA_FLGA = 3'd5,
    RA_FLGB = 3'd6
  } reg_addr_e;

  parameter logic [IDX_W-1:0] SRC_TMR0 = 3'd1;
  parameter logic [IDX_W-1:0] SRC_TMR1 = 3'd3;

  // Source index owned by external input j
  function automatic logic [IDX_W-1:0] ext_src(input int j);
    case (j)
      0:       return 3'd0;
      1:       return 3'd2;
      2:       return 3'd6;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/ivc_cfg.sv
module ivc_cfg
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   en_q,
  output logic              gen_q,
  output logic [NSRC-1:0]   phi_q,
  output logic [NSRC-1:0]   plo_q,
  output logic [NEXT-1:0]   etype_q
);
  logic [NSRC-1:0] en_d, phi_d, plo_d;
  logic            gen_d;
  logic [NEXT-1:0] etype_d;

  always_comb begin
    en_d    = en_q;
    gen_d   = gen_q;
    phi_d   = phi_q;
    plo_d   = plo_q;
    etype_d = etype_q;
    if (we) begin
      case (addr)
        RA_EN:   en_d    = wdata[NSRC-1:0];
        RA_GEN:  gen_d   = wdata[0];
        RA_PHI:  phi_d   = wdata[NSRC-1:0];
        RA_PLO:  plo_d   = wdata[NSRC-1:0];
        RA_TYPE: etype_d = wdata[NEXT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      gen_q   <= 1'b0;
      phi_q   <= '0;
      plo_q   <= '0;
      etype_q <= '0;
    end else begin
      en_q    <= en_d;
      gen_q   <= gen_d;
      phi_q   <= phi_d;
      plo_q   <= plo_d;
      etype_q <= etype_d;
    end
  end
endmodule

// File: rtl/ivc_flags.sv
module ivc_flags
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   ext_n,
  input  logic [NEXT-1:0]   etype,
  input  logic [1:0]        tmr_ovf,
  input  logic              ser_rx,
  input  logic              ser_tx,
  input  logic              t2_ovf,
  input  logic              t2_ext,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FLG_W-1:0]  wdata,
  input  logic              ack_fire,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic [NSRC-1:0]   req
);
  logic [NEXT-1:0] act_s1, act_s2, ext_q, ext_d;
  logic [1:0]      tf_q, tf_d, ser_q, ser_d, t2_q, t2_d;
  logic            wr_a, wr_b;

  assign wr_a = we && (addr == RA_FLGA);
  assign wr_b = we && (addr == RA_FLGB);

  always_comb begin
    for (int j = 0; j < NEXT; j++) begin
      if (etype[j])
        ext_d[j] = (ext_q[j] & ~(ack_fire && ack_idx == ext_src(j)))
                 | (act_s1[j] & ~act_s2[j]);
      else
        ext_d[j] = act_s1[j];
      if (wr_a) ext_d[j] = wdata[j];
    end
    tf_d[0] = (tf_q[0] & ~(ack_fire && ack_idx == SRC_TMR0)) | tmr_ovf[0];
    tf_d[1] = (tf_q[1] & ~(ack_fire && ack_idx == SRC_TMR1)) | tmr_ovf[1];
    if (wr_a) tf_d = wdata[NEXT+1:NEXT];
    ser_d = ser_q | {ser_tx, ser_rx};
    t2_d  = t2_q  | {t2_ext, t2_ovf};
    if (wr_b) begin
      ser_d = wdata[1:0];
      t2_d  = wdata[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_s1 <= '0;
      act_s2 <= '0;
      ext_q  <= '0;
      tf_q   <= '0;
      ser_q  <= '0;
      t2_q   <= '0;
    end else begin
      act_s1 <= ~ext_n;
      act_s2 <= act_s1;
      ext_q  <= ext_d;
      tf_q   <= tf_d;
      ser_q  <= ser_d;
      t2_q   <= t2_d;
    end
  end

  assign req = {ext_q[3], ext_q[2], |t2_q, |ser_q,
                tf_q[1], ext_q[1], tf_q[0], ext_q[0]};
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb
  import ivc_pkg::*;
(
  input  logic [NSRC-1:0]   req,
  input  logic [NSRC-1:0]   en,
  input  logic              gen,
  input  logic [NSRC-1:0]   phi,
  input  logic [NSRC-1:0]   plo,
  input  logic [NLVL-1:0]   isr,
  output logic              sel_vld,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [PRIO_W-1:0] sel_lvl
);
  logic [PRIO_W-1:0] cur_lvl;
  logic [PRIO_W-1:0] lvl [NSRC];
  logic [NSRC-1:0]   elig;

  always_comb begin
    cur_lvl = '0;
    for (int k = 0; k < NLVL; k++)
      if (isr[k]) cur_lvl = PRIO_W'(k);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign lvl[i]  = {phi[i], plo[i]};
    assign elig[i] = req[i] & en[i] & gen & (~|isr | (lvl[i] > cur_lvl));
  end

  // Descending scan with >= lets the lower index win a tie
  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    sel_lvl = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!sel_vld || lvl[i] >= sel_lvl)) begin
        sel_vld = 1'b1;
        sel_idx = IDX_W'(i);
        sel_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/ivc_nest.sv
module ivc_nest
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic              pop,
  output logic [NLVL-1:0]   isr_q
);
  logic [NLVL-1:0] top_oh, isr_d;

  always_comb begin
    top_oh = '0;
    for (int k = 0; k < NLVL; k++)
      if (isr_q[k]) top_oh = NLVL'(1) << k;
  end

  always_comb begin
    isr_d = isr_q;
    if (pop)  isr_d = isr_d & ~top_oh;
    if (push) isr_d = isr_d | (NLVL'(1) << push_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_bnd,
  input  logic              vec_ack,
  input  logic              irq_ret,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NEXT-1:0]   ext_n,
  input  logic [1:0]        tmr_ovf,
  input  logic              ser_rx,
  input  logic              ser_tx,
  input  logic              t2_ovf,
  input  logic              t2_ext,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_addr
);
  logic              rs1, rs2;
  logic [NSRC-1:0]   en_q, phi_q, plo_q, req;
  logic              gen_q;
  logic [NEXT-1:0]   etype_q;
  logic [NLVL-1:0]   isr_q;
  logic              sel_vld, take, fire;
  logic [IDX_W-1:0]  sel_idx, idx_q, idx_d;
  logic [PRIO_W-1:0] sel_lvl, lvl_q, lvl_d;
  logic              vld_d;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs2, rs1} <= 2'b00;
    else        {rs2, rs1} <= {rs1, 1'b1};
  end

  ivc_cfg u_cfg (
    .clk(clk), .rst_n(rs2), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .gen_q(gen_q), .phi_q(phi_q), .plo_q(plo_q), .etype_q(etype_q)
  );

  ivc_flags u_flags (
    .clk(clk), .rst_n(rs2), .ext_n(ext_n), .etype(etype_q), .tmr_ovf(tmr_ovf),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .t2_ovf(t2_ovf), .t2_ext(t2_ext),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata[FLG_W-1:0]),
    .ack_fire(fire), .ack_idx(idx_q), .req(req)
  );

  ivc_arb u_arb (
    .req(req), .en(en_q), .gen(gen_q), .phi(phi_q), .plo(plo_q), .isr(isr_q),
    .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_lvl(sel_lvl)
  );

  ivc_nest u_nest (
    .clk(clk), .rst_n(rs2), .push(fire), .push_lvl(lvl_q), .pop(irq_ret),
    .isr_q(isr_q)
  );

  assign take = insn_bnd & ~vec_valid & sel_vld;
  assign fire = vec_ack & vec_valid;

  always_comb begin
    vld_d = vec_valid;
    idx_d = idx_q;
    lvl_d = lvl_q;
    if (fire) begin
      vld_d = 1'b0;
    end else if (take) begin
      vld_d = 1'b1;
      idx_d = sel_idx;
      lvl_d = sel_lvl;
    end
  end

  always_ff @(posedge clk or negedge rs2) begin
    if (!rs2) begin
      vec_valid <= 1'b0;
      idx_q     <= '0;
      lvl_q     <= '0;
    end else begin
      vec_valid <= vld_d;
      idx_q     <= idx_d;
      lvl_q     <= lvl_d;
    end
  end

  assign vec_addr = {{(VEC_W-IDX_W-3){1'b0}}, idx_q, VEC_LOW};
endmodule

// File: rtl/ivc_check.sv
module ivc_check
  import ivc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              insn_bnd,
  input logic              vec_ack,
  input logic              irq_ret,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_addr,
  input logic              gen_q,
  input logic [NLVL-1:0]   isr_q,
  input logic [PRIO_W-1:0] lvl_q
);
  function automatic int top_lvl(input logic [NLVL-1:0] v);
    int r = 0;
    for (int k = 0; k < NLVL; k++) if (v[k]) r = k;
    return r;
  endfunction

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ack |=> vec_valid && $stable(vec_addr));

  p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ack |=> !vec_valid);

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid && !(insn_bnd && gen_q) |=> !vec_valid);

  p_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |->
      ($past(isr_q) == '0) || (int'(lvl_q) > top_lvl($past(isr_q))));

  p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ack |=> isr_q != '0);

  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret && !(vec_valid && vec_ack) && $countones(isr_q) == 1 |=> isr_q == '0);
endmodule

bind ivc_top ivc_check u_chk (
  .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .vec_ack(vec_ack),
  .irq_ret(irq_ret), .vec_valid(vec_valid), .vec_addr(vec_addr),
  .gen_q(gen_q), .isr_q(isr_q), .lvl_q(lvl_q)
);

// File: tb/ivc_top_test.sv
module ivc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // row: en, phi, plo, flags A, flags B, expect valid, expect index
  localparam logic [43:0] TBL [8] = '{
    {8'hFF, 8'h00, 8'h00, 8'h3F, 8'h0F, 1'b1, 3'd0},
    {8'hFF, 8'h00, 8'h00, 8'h20, 8'h02, 1'b1, 3'd3},
    {8'hFF, 8'h80, 8'h00, 8'h19, 8'h00, 1'b1, 3'd7},
    {8'hFF, 8'h00, 8'h20, 8'h01, 8'h04, 1'b1, 3'd5},
    {8'hFE, 8'h00, 8'h00, 8'h11, 8'h00, 1'b1, 3'd1},
    {8'h00, 8'h00, 8'h00, 8'h3F, 8'h0F, 1'b0, 3'd0},
    {8'hFF, 8'h44, 8'h40, 8'h06, 8'h00, 1'b1, 3'd6},
    {8'hFF, 8'h10, 8'h08, 8'h20, 8'h01, 1'b1, 3'd4}
  };

  logic       clk = 1'b0;
  logic       rst_n, insn_bnd, vec_ack, irq_ret, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [3:0] ext_n;
  logic [1:0] tmr_ovf;
  logic       ser_rx, ser_tx, t2_ovf, t2_ext;
  logic       vec_valid;
  logic [7:0] vec_addr;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [43:0] row;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivc_top uut (
    .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .vec_ack(vec_ack),
    .irq_ret(irq_ret), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .t2_ovf(t2_ovf), .t2_ext(t2_ext),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  function automatic logic [7:0] vaddr(input int idx);
    return 8'h03 + 8'(8 * idx);
  endfunction

  task automatic chk(input string tag, input logic ev, input logic [7:0] ea);
    n_cmp++;
    if (vec_valid !== ev || (ev && vec_addr !== ea)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b addr=%h, expected valid=%0b addr=%h",
               tag, vec_valid, vec_addr, ev, ea);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic strobe();
    insn_bnd = 1'b1;
    @(negedge clk);
    insn_bnd = 1'b0;
  endtask

  task automatic ack();
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; insn_bnd = 1'b0; vec_ack = 1'b0; irq_ret = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; ext_n = 4'hF;
    tmr_ovf = '0; ser_rx = 0; ser_tx = 0; t2_ovf = 0; t2_ext = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state, nothing presented and nothing pending
    chk("R10 after reset", 1'b0, 8'h00);
    strobe();
    chk("R10 strobe with reset registers", 1'b0, 8'h00);

    // Table: R1 R2 R3 R4 under varied enables, levels and flags
    wr(3'd1, 8'h01);
    for (int t = 0; t < 8; t++) begin
      row = TBL[t];
      wr(3'd4, 8'h0F);
      wr(3'd0, row[43:36]);
      wr(3'd2, row[35:28]);
      wr(3'd3, row[27:20]);
      wr(3'd5, row[19:12]);
      wr(3'd6, row[11:4]);
      strobe();
      chk($sformatf("R1 R2 R3 R4 table row %0d", t), row[3], vaddr(int'(row[2:0])));
      if (vec_valid) begin ack(); ret(); end
      wr(3'd5, 8'h00);
      wr(3'd6, 8'h00);
    end
    wr(3'd0, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R1: global enable off masks a pending timer0 flag
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h10);
    strobe();
    chk("R1 global enable off", 1'b0, 8'h00);
    wr(3'd1, 8'h01);
    strobe();
    chk("R1 global enable on", 1'b1, vaddr(1));
    ack();
    chk("R4 valid falls on ack", 1'b0, 8'h00);
    ret();
    strobe();
    chk("R7 timer0 flag cleared on ack", 1'b0, 8'h00);

    // R11: timer1 set pulse
    tmr_ovf = 2'b10; @(negedge clk); tmr_ovf = 2'b00;
    strobe();
    chk("R11 timer1 pulse", 1'b1, vaddr(3));
    ack(); ret();

    // R8 R11: serial flag survives ack; R9 software clear withdraws it
    ser_rx = 1'b1; @(negedge clk); ser_rx = 1'b0;
    strobe();
    chk("R11 serial rx pulse", 1'b1, vaddr(4));
    ack(); ret();
    strobe();
    chk("R8 serial flag kept after ack", 1'b1, vaddr(4));
    ack(); ret();
    wr(3'd6, 8'h00);
    strobe();
    chk("R9 software clear of serial", 1'b0, 8'h00);

    // R8: timer2 capture pulse
    t2_ext = 1'b1; @(negedge clk); t2_ext = 1'b0;
    strobe();
    chk("R8 timer2 capture request", 1'b1, vaddr(5));
    ack(); ret();
    strobe();
    chk("R8 timer2 flag kept after ack", 1'b1, vaddr(5));
    ack(); ret();
    wr(3'd6, 8'h00);

    // R6 R7: edge mode on ext1
    wr(3'd4, 8'h0F);
    ext_n[1] = 1'b0;
    repeat (3) @(negedge clk);
    strobe();
    chk("R6 falling edge ext1", 1'b1, vaddr(2));
    ack(); ret();
    strobe();
    chk("R7 edge flag cleared, pin still low", 1'b0, 8'h00);
    ext_n[1] = 1'b1;
    repeat (3) @(negedge clk);

    // R6 R7: level mode on ext2
    wr(3'd4, 8'h00);
    ext_n[2] = 1'b0;
    repeat (3) @(negedge clk);
    strobe();
    chk("R6 level low ext2", 1'b1, vaddr(6));
    ack(); ret();
    strobe();
    chk("R7 level flag not cleared", 1'b1, vaddr(6));
    ack(); ret();
    ext_n[2] = 1'b1;
    repeat (3) @(negedge clk);
    strobe();
    chk("R6 level flag follows released pin", 1'b0, 8'h00);

    // R5: nesting
    wr(3'd4, 8'h0F);
    wr(3'd2, 8'h80);
    wr(3'd3, 8'h92);
    wr(3'd6, 8'h01);
    strobe();
    chk("R5 serial at level 1", 1'b1, vaddr(4));
    ack();
    wr(3'd5, 8'h10);
    strobe();
    chk("R5 same level cannot nest", 1'b0, 8'h00);
    wr(3'd5, 8'h18);
    strobe();
    chk("R5 level 3 nests over level 1", 1'b1, vaddr(7));
    ack();
    strobe();
    chk("R5 nothing above level 3", 1'b0, 8'h00);
    ret();
    strobe();
    chk("R5 level 1 still in service", 1'b0, 8'h00);
    ret();
    strobe();
    chk("R5 R3 after both returns", 1'b1, vaddr(1));
    ack(); ret();
    wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R4: held vector ignores a better request until ack
    wr(3'd5, 8'h20);
    strobe();
    chk("R4 timer1 presented", 1'b1, vaddr(3));
    wr(3'd5, 8'h21);
    repeat (2) @(negedge clk);
    strobe();
    chk("R4 vector held without ack", 1'b1, vaddr(3));
    ack();
    chk("R4 dropped after ack", 1'b0, 8'h00);
    ret();
    strobe();
    chk("R3 ext0 after held vector", 1'b1, vaddr(0));
    ack(); ret();

    finish_run();
  end
endmodule